// File: doc/BRIEF.md
# PLL Divider Search Engine

This block finds a reference divider M, a feedback divider N and a postscaler P for a frequency-synthesis PLL so that the synthesized output comes as close as possible to a requested frequency. All frequencies are unsigned fixed-point MHz with 8 fractional bits. A one-cycle start pulse samples the request and the PLL limits: the reference frequency, the minimum and maximum VCO frequency, and the maximum output frequency. The engine then runs an exhaustive search over P and M. Each candidate uses a shared iterative restoring divider, so one candidate takes several tens of cycles.

The request is first clamped into the legal range. The engine then visits P = 1, 2, 4, 8 in that order. For each P whose VCO frequency lies inside the window, it sweeps M upward from 2 to 32 and computes a rounded N. Candidates with N outside 8..128 are dropped. The engine keeps the candidate with the smallest absolute output error. When the search ends it reports the encoded divider codes, a loop-filter range chosen from the resulting VCO frequency, that VCO frequency and the achieved output frequency, together with a one-cycle done strobe. When no candidate qualifies it reports zeros and raises a failure flag.

Top module: `pll_divider_search`

## Requirements
- R1: After reset, busy_o, done_o and fail_o are 0 and every code and frequency output is 0.
- R2: A request below floor(vco_min / 8) is raised to floor(vco_min / 8) before the search.
- R3: After the R2 step, a request above out_max is lowered to out_max.
- R4: P is tried as 1, 2, 4, 8 in that order. A P is used only if req × P lies within [vco_min, vco_max], both bounds inclusive.
- R5: For each usable P, M runs upward from 2 to 32. N = floor((req × P × M + floor(ref/2)) / ref). A candidate is skipped if N < 8 or N > 128.
- R6: The candidate error is |req − floor(ref × N / (M × P))|. A later candidate replaces the kept one only if its error is strictly smaller.
- R7: m_code_o = M − 1 and n_code_o = N − 1. p_code_o bits 2:0 hold P − 1.
- R8: p_code_o bits 4:3 hold the loop-filter range, taken from vco = floor(ref × N / M). The value is 3 when vco ≥ 240 MHz, else 2 when vco ≥ 170 MHz, else 1 when vco ≥ 110 MHz, else 0.
- R9: vco_freq_o reports that vco, and ach_freq_o reports floor(vco / P).
- R10: busy_o is high from the cycle after an accepted start up to and including the cycle in which done_o is high. done_o is a single-cycle pulse, and all results are valid in that cycle.
- R11: If no candidate qualifies, fail_o is 1 and all code and frequency outputs are 0. Otherwise fail_o is 0.
- R12: A start pulse while busy_o is high is ignored.
- R13: The request and limits are sampled only at an accepted start. Later changes on those inputs do not affect the running search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a search (accepted when idle) |
| req_freq_i | input | 20 | Requested output frequency, Q12.8 MHz |
| ref_freq_i | input | 20 | Reference frequency, Q12.8 MHz |
| vco_min_i | input | 20 | Lowest legal VCO frequency, Q12.8 MHz |
| vco_max_i | input | 20 | Highest legal VCO frequency, Q12.8 MHz |
| out_max_i | input | 20 | Highest legal output frequency, Q12.8 MHz |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion strobe |
| fail_o | output | 1 | No qualifying candidate found |
| m_code_o | output | 5 | Encoded reference divider, M − 1 |
| n_code_o | output | 7 | Encoded feedback divider, N − 1 |
| p_code_o | output | 5 | {loop-filter range[1:0], P − 1[2:0]} |
| vco_freq_o | output | 32 | VCO frequency of the chosen setting, Q.8 MHz |
| ach_freq_o | output | 32 | Achieved output frequency, Q.8 MHz |

## Verification
The search length depends on how many postscalers fall inside the window and how many N values survive the range check. No result has a fixed latency after start. Only two timings are fixed: busy_o rises one cycle after the start edge, and every result output becomes valid in the single cycle that done_o is high. The bench therefore polls done_o on falling edges and samples all six result fields in that same half-cycle. One falling edge later it checks that done_o has dropped. For the ignored-start and sampled-input cases, the bench disturbs the inputs 20 cycles into a run while busy_o is confirmed high, and compares the final results against the undisturbed expectation.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

    localparam int FRAC_BITS   = 8;
    localparam int FREQ_W      = 20;
    localparam int P_STEPS     = 4;
    localparam int M_LO        = 2;
    localparam int M_HI        = 32;
    localparam int N_LO        = 8;
    localparam int N_HI        = 128;
    localparam int DIV_W       = 32;

    localparam int VCO_W       = FREQ_W + P_STEPS;
    localparam int P_IDX_W     = $clog2(P_STEPS + 1);
    localparam int M_W         = $clog2(M_HI + 1);
    localparam int N_W         = $clog2(N_HI + 1);
    localparam int M_CODE_W    = $clog2(M_HI);
    localparam int N_CODE_W    = $clog2(N_HI);
    localparam int PF_W        = $clog2(1 << (P_STEPS - 1));
    localparam int FILT_W      = 2;
    localparam int P_CODE_W    = PF_W + FILT_W;
    localparam int CLAMP_SHIFT = P_STEPS - 1;

    localparam logic [DIV_W-1:0] FILT_T3 = DIV_W'(240) << FRAC_BITS;
    localparam logic [DIV_W-1:0] FILT_T2 = DIV_W'(170) << FRAC_BITS;
    localparam logic [DIV_W-1:0] FILT_T1 = DIV_W'(110) << FRAC_BITS;

    typedef enum logic [3:0] {
        S_IDLE, S_PCHK, S_NDIV, S_NWAIT, S_ODIV,
        S_OWAIT, S_MNEXT, S_FVCO, S_FVWAIT, S_DONE
    } srch_state_t;

    typedef struct packed {
        logic [FREQ_W-1:0] ref_f;
        logic [FREQ_W-1:0] vmin;
        logic [FREQ_W-1:0] vmax;
    } lim_cfg_t;

    typedef struct packed {
        logic               found;
        logic [M_W-1:0]     m;
        logic [N_W-1:0]     n;
        logic [P_IDX_W-1:0] pidx;
        logic [DIV_W-1:0]   err;
    } cand_t;

    function automatic logic [FILT_W-1:0] filter_range(input logic [DIV_W-1:0] vco);
        if (vco >= FILT_T3)      return 2'd3;
        else if (vco >= FILT_T2) return 2'd2;
        else if (vco >= FILT_T1) return 2'd1;
        else                     return 2'd0;
    endfunction

    function automatic logic [DIV_W-1:0] abs_gap(input logic [DIV_W-1:0] a,
                                                 input logic [DIV_W-1:0] b);
        return (a >= b) ? (a - b) : (b - a);
    endfunction

    function automatic logic [FREQ_W-1:0] clamp_req(input logic [FREQ_W-1:0] req,
                                                    input logic [FREQ_W-1:0] vmin,
                                                    input logic [FREQ_W-1:0] omax);
        logic [FREQ_W-1:0] floor_v;
        logic [FREQ_W-1:0] r;
        floor_v = vmin >> CLAMP_SHIFT;
        r = (req < floor_v) ? floor_v : req;
        r = (r > omax) ? omax : r;
        return r;
    endfunction

endpackage

// File: rtl/pll_restoring_div.sv
module pll_restoring_div #(
    parameter int DW = 32,
    parameter int VW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [DW-1:0] dividend,
    input  logic [VW-1:0] divisor,
    output logic          done,
    output logic [DW-1:0] quotient
);
    localparam int CW = $clog2(DW + 1);

    logic          run;
    logic [CW-1:0] cnt;
    logic [VW-1:0] rem;
    logic [VW-1:0] dvs_r;
    logic [DW-1:0] quo;
    logic [VW:0]   trial;
    logic [VW:0]   diff;
    logic          fits;

    always_comb begin
        trial = {rem, quo[DW-1]};
        fits  = trial >= {1'b0, dvs_r};
        diff  = trial - {1'b0, dvs_r};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run   <= 1'b0;
            cnt   <= '0;
            rem   <= '0;
            dvs_r <= '0;
            quo   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                run   <= 1'b1;
                cnt   <= '0;
                rem   <= '0;
                quo   <= dividend;
                dvs_r <= divisor;
            end else if (run) begin
                rem <= fits ? diff[VW-1:0] : trial[VW-1:0];
                quo <= {quo[DW-2:0], fits};
                cnt <= cnt + 1'b1;
                if (cnt == CW'(DW - 1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quotient = quo;
endmodule

// File: rtl/pll_code_pack.sv
module pll_code_pack
    import pll_search_pkg::*;
(
    input  logic [M_W-1:0]      m_val,
    input  logic [N_W-1:0]      n_val,
    input  logic [P_IDX_W-1:0]  p_idx,
    input  logic [DIV_W-1:0]    vco,
    output logic [M_CODE_W-1:0] m_code,
    output logic [N_CODE_W-1:0] n_code,
    output logic [P_CODE_W-1:0] p_code
);
    logic [M_W-1:0]  m_dec;
    logic [N_W-1:0]  n_dec;
    logic [PF_W:0]   p_val;
    logic [PF_W:0]   p_dec;

    always_comb begin
        m_dec  = m_val - M_W'(1);
        n_dec  = n_val - N_W'(1);
        p_val  = (PF_W + 1)'(1) << p_idx;
        p_dec  = p_val - (PF_W + 1)'(1);
        m_code = m_dec[M_CODE_W-1:0];
        n_code = n_dec[N_CODE_W-1:0];
        p_code = {filter_range(vco), p_dec[PF_W-1:0]};
    end
endmodule

// File: rtl/pll_divider_search.sv
module pll_divider_search
    import pll_search_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [FREQ_W-1:0]   req_freq_i,
    input  logic [FREQ_W-1:0]   ref_freq_i,
    input  logic [FREQ_W-1:0]   vco_min_i,
    input  logic [FREQ_W-1:0]   vco_max_i,
    input  logic [FREQ_W-1:0]   out_max_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                fail_o,
    output logic [M_CODE_W-1:0] m_code_o,
    output logic [N_CODE_W-1:0] n_code_o,
    output logic [P_CODE_W-1:0] p_code_o,
    output logic [DIV_W-1:0]    vco_freq_o,
    output logic [DIV_W-1:0]    ach_freq_o
);
    srch_state_t          state;
    lim_cfg_t             cfg;
    cand_t                best;
    logic [FREQ_W-1:0]    req_r;
    logic [P_IDX_W-1:0]   p_idx;
    logic [M_W-1:0]       m_r;
    logic [N_W-1:0]       n_r;

    logic [VCO_W-1:0]     vco_cur;
    logic                 in_win;
    logic                 div_go;
    logic [DIV_W-1:0]     div_dvd;
    logic [FREQ_W-1:0]    div_dvs;
    logic                 div_done;
    logic [DIV_W-1:0]     div_q;
    logic [DIV_W-1:0]     err_now;
    logic                 n_ok;

    logic [M_CODE_W-1:0]  pk_m;
    logic [N_CODE_W-1:0]  pk_n;
    logic [P_CODE_W-1:0]  pk_p;

    // Candidate VCO for the current postscaler and window test
    always_comb begin
        vco_cur = VCO_W'(req_r) << p_idx;
        in_win  = (vco_cur >= VCO_W'(cfg.vmin)) && (vco_cur <= VCO_W'(cfg.vmax));
        err_now = abs_gap(DIV_W'(req_r), div_q);
        n_ok    = (div_q >= DIV_W'(N_LO)) && (div_q <= DIV_W'(N_HI));
    end

    // Shared divider operand selection
    always_comb begin
        div_go  = 1'b0;
        div_dvd = '0;
        div_dvs = '0;
        case (state)
            S_NDIV: begin
                div_go  = 1'b1;
                div_dvd = DIV_W'(vco_cur) * DIV_W'(m_r) + DIV_W'(cfg.ref_f >> 1);
                div_dvs = cfg.ref_f;
            end
            S_ODIV: begin
                div_go  = 1'b1;
                div_dvd = DIV_W'(cfg.ref_f) * DIV_W'(n_r);
                div_dvs = FREQ_W'(m_r) << p_idx;
            end
            S_FVCO: begin
                div_go  = best.found;
                div_dvd = DIV_W'(cfg.ref_f) * DIV_W'(best.n);
                div_dvs = FREQ_W'(best.m);
            end
            default: ;
        endcase
    end

    pll_restoring_div #(
        .DW (DIV_W),
        .VW (FREQ_W)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .go       (div_go),
        .dividend (div_dvd),
        .divisor  (div_dvs),
        .done     (div_done),
        .quotient (div_q)
    );

    pll_code_pack u_pack (
        .m_val  (best.m),
        .n_val  (best.n),
        .p_idx  (best.pidx),
        .vco    (div_q),
        .m_code (pk_m),
        .n_code (pk_n),
        .p_code (pk_p)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            cfg        <= '0;
            best       <= '0;
            req_r      <= '0;
            p_idx      <= '0;
            m_r        <= '0;
            n_r        <= '0;
            fail_o     <= 1'b0;
            m_code_o   <= '0;
            n_code_o   <= '0;
            p_code_o   <= '0;
            vco_freq_o <= '0;
            ach_freq_o <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (start_i) begin
                        cfg.ref_f <= ref_freq_i;
                        cfg.vmin  <= vco_min_i;
                        cfg.vmax  <= vco_max_i;
                        req_r     <= clamp_req(req_freq_i, vco_min_i, out_max_i);
                        best      <= '0;
                        p_idx     <= '0;
                        state     <= S_PCHK;
                    end
                end
                S_PCHK: begin
                    if (p_idx == P_IDX_W'(P_STEPS)) begin
                        state <= S_FVCO;
                    end else if (in_win) begin
                        m_r   <= M_W'(M_LO);
                        state <= S_NDIV;
                    end else begin
                        p_idx <= p_idx + 1'b1;
                    end
                end
                S_NDIV: state <= S_NWAIT;
                S_NWAIT: begin
                    if (div_done) begin
                        if (n_ok) begin
                            n_r   <= N_W'(div_q);
                            state <= S_ODIV;
                        end else begin
                            state <= S_MNEXT;
                        end
                    end
                end
                S_ODIV: state <= S_OWAIT;
                S_OWAIT: begin
                    if (div_done) begin
                        if (!best.found || (err_now < best.err)) begin
                            best.found <= 1'b1;
                            best.m     <= m_r;
                            best.n     <= n_r;
                            best.pidx  <= p_idx;
                            best.err   <= err_now;
                        end
                        state <= S_MNEXT;
                    end
                end
                S_MNEXT: begin
                    if (m_r == M_W'(M_HI)) begin
                        p_idx <= p_idx + 1'b1;
                        state <= S_PCHK;
                    end else begin
                        m_r   <= m_r + 1'b1;
                        state <= S_NDIV;
                    end
                end
                S_FVCO: begin
                    if (best.found) begin
                        state <= S_FVWAIT;
                    end else begin
                        fail_o     <= 1'b1;
                        m_code_o   <= '0;
                        n_code_o   <= '0;
                        p_code_o   <= '0;
                        vco_freq_o <= '0;
                        ach_freq_o <= '0;
                        state      <= S_DONE;
                    end
                end
                S_FVWAIT: begin
                    if (div_done) begin
                        fail_o     <= 1'b0;
                        m_code_o   <= pk_m;
                        n_code_o   <= pk_n;
                        p_code_o   <= pk_p;
                        vco_freq_o <= div_q;
                        ach_freq_o <= div_q >> best.pidx;
                        state      <= S_DONE;
                    end
                end
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy_o = (state != S_IDLE);
    assign done_o = (state == S_DONE);
endmodule

// File: rtl/pll_search_chk.sv
module pll_search_chk
    import pll_search_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                start_i,
    input logic                busy_o,
    input logic                done_o,
    input logic                fail_o,
    input logic [M_CODE_W-1:0] m_code_o,
    input logic [N_CODE_W-1:0] n_code_o,
    input logic [P_CODE_W-1:0] p_code_o,
    input logic [DIV_W-1:0]    vco_freq_o,
    input logic [DIV_W-1:0]    ach_freq_o
);
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_done_in_busy_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> busy_o);

    p_start_busy_r10: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    p_fail_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (done_o && fail_o) |-> (m_code_o == '0 && n_code_o == '0 && p_code_o == '0
                                && vco_freq_o == '0 && ach_freq_o == '0));

    p_code_range_r7: assert property (@(posedge clk) disable iff (rst)
        (done_o && !fail_o) |-> (m_code_o >= M_CODE_W'(M_LO - 1)
                                 && n_code_o >= N_CODE_W'(N_LO - 1)
                                 && $countones(p_code_o[PF_W-1:0] + PF_W'(1)) <= 1));

    p_ach_bound_r9: assert property (@(posedge clk) disable iff (rst)
        (done_o && !fail_o) |-> (ach_freq_o <= vco_freq_o));
endmodule

bind pll_divider_search pll_search_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .fail_o     (fail_o),
    .m_code_o   (m_code_o),
    .n_code_o   (n_code_o),
    .p_code_o   (p_code_o),
    .vco_freq_o (vco_freq_o),
    .ach_freq_o (ach_freq_o)
);

// File: tb/tb_pll_divider_search.sv
module tb_pll_divider_search;
    import pll_search_pkg::*;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                start_i = 1'b0;
    logic [FREQ_W-1:0]   req_freq_i = '0;
    logic [FREQ_W-1:0]   ref_freq_i = '0;
    logic [FREQ_W-1:0]   vco_min_i = '0;
    logic [FREQ_W-1:0]   vco_max_i = '0;
    logic [FREQ_W-1:0]   out_max_i = '0;
    logic                busy_o, done_o, fail_o;
    logic [M_CODE_W-1:0] m_code_o;
    logic [N_CODE_W-1:0] n_code_o;
    logic [P_CODE_W-1:0] p_code_o;
    logic [DIV_W-1:0]    vco_freq_o, ach_freq_o;

    int checks = 0;
    int failures = 0;
    localparam int CASE_LIMIT = 12000;

    always #5 clk = ~clk;

    pll_divider_search dut (.*);

    function automatic longint mhz(input int v);
        return longint'(v) << FRAC_BITS;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected results computed from the requirement text
    task automatic model(input longint rq, input longint rf, input longint vn, input longint vx,
                         input longint mo, output bit fl, output longint mc, output longint nc,
                         output longint pc, output longint vc, output longint ac);
        longint r, lo, v, n, o, e, be, bm, bn, bp, filt;
        bit found;
        lo = vn >> 3;
        r  = (rq < lo) ? lo : rq;
        r  = (r > mo) ? mo : r;
        found = 0; be = 0; bm = 0; bn = 0; bp = 0;
        for (int pi = 0; pi < 4; pi++) begin
            v = r << pi;
            if (v >= vn && v <= vx) begin
                for (int m = 2; m <= 32; m++) begin
                    n = (v * m + rf / 2) / rf;
                    if (n < 8 || n > 128) continue;
                    o = (rf * n) / (longint'(m) << pi);
                    e = (r >= o) ? r - o : o - r;
                    if (!found || e < be) begin
                        found = 1; be = e; bm = m; bn = n; bp = pi;
                    end
                end
            end
        end
        if (!found) begin
            fl = 1; mc = 0; nc = 0; pc = 0; vc = 0; ac = 0;
        end else begin
            fl = 0;
            vc = (rf * bn) / bm;
            if (vc >= mhz(240))      filt = 3;
            else if (vc >= mhz(170)) filt = 2;
            else if (vc >= mhz(110)) filt = 1;
            else                     filt = 0;
            mc = bm - 1;
            nc = bn - 1;
            pc = (filt << 3) | ((longint'(1) << bp) - 1);
            ac = vc >> bp;
        end
    endtask

    task automatic run_case(input longint rq, input longint rf, input longint vn, input longint vx,
                            input longint mo, input bit disturb, input string tag);
        bit fl;
        longint mc, nc, pc, vc, ac;
        int cyc;
        model(rq, rf, vn, vx, mo, fl, mc, nc, pc, vc, ac);
        @(negedge clk);
        req_freq_i = FREQ_W'(rq);
        ref_freq_i = FREQ_W'(rf);
        vco_min_i  = FREQ_W'(vn);
        vco_max_i  = FREQ_W'(vx);
        out_max_i  = FREQ_W'(mo);
        start_i    = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, {tag, " R10 busy after start"}, longint'(busy_o), 1);
        if (disturb) begin
            repeat (20) @(negedge clk);
            check(busy_o == 1'b1 && done_o == 1'b0, {tag, " R12 still busy"}, longint'(busy_o), 1);
            // R12 start while busy, R13 inputs changed mid-search
            req_freq_i = FREQ_W'(rq + mhz(37));
            ref_freq_i = FREQ_W'(rf + mhz(3));
            vco_min_i  = FREQ_W'(vn / 2);
            vco_max_i  = FREQ_W'(vx + mhz(50));
            out_max_i  = FREQ_W'(mo / 2);
            start_i    = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        cyc = 0;
        while (!done_o && cyc < CASE_LIMIT) begin
            @(negedge clk);
            cyc++;
        end
        if (!done_o) begin
            check(1'b0, {tag, " watchdog"}, longint'(cyc), CASE_LIMIT);
            return;
        end
        check(fail_o == fl,           {tag, " R11 fail flag"},   longint'(fail_o), longint'(fl));
        check(m_code_o == mc,         {tag, " R7 R6 m_code"},    longint'(m_code_o), mc);
        check(n_code_o == nc,         {tag, " R7 R5 n_code"},    longint'(n_code_o), nc);
        check(p_code_o == pc,         {tag, " R7 R8 p_code"},    longint'(p_code_o), pc);
        check(vco_freq_o == vc,       {tag, " R9 vco"},          longint'(vco_freq_o), vc);
        check(ach_freq_o == ac,       {tag, " R9 achieved"},     longint'(ach_freq_o), ac);
        @(negedge clk);
        check(done_o == 1'b0,         {tag, " R10 done pulse"},  longint'(done_o), 0);
        check(busy_o == 1'b0,         {tag, " R10 busy drop"},   longint'(busy_o), 0);
    endtask

    initial begin
        int seed;
        longint rf, vn, vx, mo, rq;
        seed = 20240611;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy_o == 0 && done_o == 0 && fail_o == 0, "R1 reset flags", longint'(busy_o), 0);
        check(m_code_o == 0 && n_code_o == 0 && p_code_o == 0, "R1 reset codes",
              longint'(m_code_o), 0);
        check(vco_freq_o == 0 && ach_freq_o == 0, "R1 reset freqs", longint'(vco_freq_o), 0);
        rst = 1'b0;

        run_case(mhz(65), mhz(27), mhz(50), mhz(310), mhz(250), 0, "R4 R6 typical");
        run_case(mhz(1), mhz(27), mhz(50), mhz(310), mhz(250), 0, "R2 low clamp");
        run_case(mhz(900), mhz(27), mhz(50), mhz(310), mhz(200), 0, "R3 high clamp");
        run_case(mhz(30), mhz(27), mhz(200), mhz(201), mhz(30), 0, "R4 R11 empty window");
        run_case(mhz(100), mhz(4000), mhz(50), mhz(300), mhz(250), 0, "R5 R11 n limit");
        run_case(mhz(250), mhz(27), mhz(50), mhz(400), mhz(300), 0, "R8 filter high");
        run_case(mhz(180), mhz(27), mhz(50), mhz(400), mhz(300), 0, "R8 filter mid");
        run_case(mhz(120), mhz(25), mhz(100), mhz(130), mhz(300), 0, "R8 filter low");
        run_case(mhz(60), mhz(14), mhz(50), mhz(100), mhz(300), 0, "R8 filter zero");
        run_case(mhz(65) + 77, mhz(27), mhz(50), mhz(310), mhz(250), 1, "R12 R13 disturb");

        for (int i = 0; i < 8; i++) begin
            rf = longint'($urandom_range(10 << 8, 60 << 8));
            vn = longint'($urandom_range(50 << 8, 120 << 8));
            vx = vn + longint'($urandom_range(100 << 8, 300 << 8));
            mo = longint'($urandom_range(100 << 8, 400 << 8));
            rq = longint'($urandom_range(0, 500 << 8));
            run_case(rq, rf, vn, vx, mo, 0, "R6 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule